// File: doc/BRIEF.md
# ECC Check-Bit Error Injector

This block sits on the write path of a memory controller, between the ECC encoder and the storage array. It lets test software deliberately corrupt the check bits of exactly one future write, so that the read-side checker and its interrupt and report path can be exercised on demand. Software loads an injection register that holds a check-bit XOR pattern, a writeback-enable flag and a self-clearing arm bit. The next write that passes through leaves with its encoder check bits XORed with the pattern. Every write after that passes through unchanged.

Software chooses the pattern, and the pattern sets the kind of error that later reads report. A correctable error on data bit n uses the column syndrome of that data bit (for example 0xF4 for data bit 0). A correctable error on check bit n uses a pattern with only bit n set. An uncorrectable error uses 0x03, which flips two check bits. Software sets the writeback-enable flag for correctable injections, so the read path scrubs the corrected word back to memory. Software leaves the flag clear for uncorrectable injections.

A busy output stays high while earlier writes are still in the controller pipeline. Software waits for busy to read low before it programs an injection.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset, busy is 0, scrub_en is 0 and no injection is armed, so wr_check_out equals wr_check_in.
- R2: While no injection is armed, a write leaves with wr_check_out equal to wr_check_in, in the same cycle.
- R3: On the first write after arming, wr_check_out equals wr_check_in XOR the pattern, which is taken from bits [23:16] of the last value written to the injection register.
- R4: The arm bit clears by itself after it has been applied to one write. The write that follows passes through unchanged.
- R5: A configuration write to address INJ_ADDR with bit 8 set arms an injection. A write to any other address has no effect. A write to INJ_ADDR with bit 8 clear leaves the block disarmed.
- R6: scrub_en follows bit 24 of the last value written to the injection register, starting in the cycle after that write.
- R7: busy goes high in the cycle after a write is accepted. It stays high until PIPE_DEPTH cycles after the last accepted write, and then falls to 0.
- R8: If a configuration write and a data write occur in the same cycle, the data write uses the arm state from before that cycle. The new configuration, including a new arm, takes effect in the next cycle and takes priority over the self-clear.
- R9: An armed injection stays armed through any number of idle cycles until a write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration write address |
| cfg_wdata | input | 32 | Configuration write data |
| wr_valid | input | 1 | A data write is passing in this cycle |
| wr_check_in | input | CHK_W | Check bits from the ECC encoder |
| wr_check_out | output | CHK_W | Check bits sent to the array, possibly corrupted |
| busy | output | 1 | Writes are still pending in the pipeline |
| scrub_en | output | 1 | Writeback enable seen by the read path |

## Verification
Injection is tried with three patterns: the syndrome of a single data bit (0xF4), one check bit (0x80) and the two-bit pattern 0x03. These confirm that the pattern field is applied bit-exact and not just a parity-style flip. A second write right after each injection tells a one-shot arm apart from a sticky one. A write to the wrong address and a write with the arm bit clear tell real arming apart from loose decoding. A configuration write placed in the same cycle as a data write, and a long idle gap before the write, pin down the timing of the arm state. A single write and a burst of back-to-back writes measure the exact length of the busy window.

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl #(
  parameter int ADDR_W     = 8,
  parameter int CHK_W      = 8,
  parameter int PIPE_DEPTH = 3,
  parameter logic [ADDR_W-1:0] INJ_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              wr_valid,
  input  logic [CHK_W-1:0]  wr_check_in,
  output logic [CHK_W-1:0]  wr_check_out,
  output logic              busy,
  output logic              scrub_en
);
  localparam int PAT_LSB = 16;
  localparam int WB_BIT  = 24;
  localparam int FWC_BIT = 8;

  logic             armed;
  logic [CHK_W-1:0] pattern;
  logic             cfg_hit;
  logic [PIPE_DEPTH-1:0] pend;

  assign cfg_hit = cfg_we && (cfg_addr == INJ_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      pattern  <= '0;
      scrub_en <= 1'b0;
    end else if (cfg_hit) begin
      armed    <= cfg_wdata[FWC_BIT];
      pattern  <= cfg_wdata[PAT_LSB +: CHK_W];
      scrub_en <= cfg_wdata[WB_BIT];
    end else if (armed && wr_valid) begin
      armed <= 1'b0;
    end
  end

  assign wr_check_out = (armed && wr_valid) ? (wr_check_in ^ pattern) : wr_check_in;

  generate
    if (PIPE_DEPTH == 1) begin : g_pipe1
      always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= wr_valid;
      end
    end else begin : g_pipen
      always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= {pend[PIPE_DEPTH-2:0], wr_valid};
      end
    end
  endgenerate

  assign busy = |pend;

  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && wr_valid) |-> (wr_check_out == wr_check_in));

  a_r3_pattern_applied: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_valid) |-> ((wr_check_out ^ wr_check_in) == pattern));

  a_r4_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_valid && !cfg_hit) |=> !armed);

  a_r8_cfg_priority: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> (armed == $past(cfg_wdata[FWC_BIT])));

  a_r7_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> busy);

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !wr_valid && !cfg_hit) |=> armed);
endmodule

// File: tb/sim_ecc_inject_ctrl.sv
`timescale 1ns/1ps
module sim_ecc_inject_ctrl;
  localparam int PD = 3;
  localparam logic [7:0] INJ = 8'h10;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [7:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic wr_valid = 0;
  logic [7:0] wr_check_in = 0;
  logic [7:0] wr_check_out;
  logic busy, scrub_en;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ecc_inject_ctrl #(.ADDR_W(8), .CHK_W(8), .PIPE_DEPTH(PD), .INJ_ADDR(INJ)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wr_valid(wr_valid), .wr_check_in(wr_check_in),
    .wr_check_out(wr_check_out), .busy(busy), .scrub_en(scrub_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] inj_word(input logic [7:0] pat, input logic wb, input logic fwc);
    return {7'd0, wb, pat, 7'd0, fwc, 8'd0};
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic data_write(input logic [7:0] c, output logic [7:0] got);
    @(negedge clk);
    wr_valid = 1; wr_check_in = c;
    #1 got = wr_check_out;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 scrub_en", scrub_en, 0);
    wr_check_in = 8'h3C; wr_valid = 1; #0.5;
    chk("R1 passthrough", wr_check_out, 8'h3C);
    wr_valid = 0;
  endtask

  task automatic t_passthrough();
    logic [7:0] g;
    data_write(8'hA5, g); chk("R2 passthrough A5", g, 8'hA5);
    data_write(8'h00, g); chk("R2 passthrough 00", g, 8'h00);
    wait_idle();
  endtask

  task automatic t_inject(input logic [7:0] pat, input logic wb, input logic [7:0] c);
    logic [7:0] g;
    wait_idle();
    cfg_write(INJ, inj_word(pat, wb, 1'b1));
    chk("R6 scrub_en", scrub_en, wb);
    data_write(c, g); chk("R3 injected", g, c ^ pat);
    data_write(c, g); chk("R4 one shot", g, c);
    wait_idle();
  endtask

  task automatic t_no_arm();
    logic [7:0] g;
    cfg_write(8'h11, inj_word(8'hFF, 1'b1, 1'b1));
    data_write(8'h12, g); chk("R5 other address ignored", g, 8'h12);
    cfg_write(INJ, inj_word(8'hFF, 1'b0, 1'b0));
    data_write(8'h34, g); chk("R5 arm bit clear", g, 8'h34);
    wait_idle();
  endtask

  task automatic t_same_cycle();
    logic [7:0] g;
    @(negedge clk);
    cfg_we = 1; cfg_addr = INJ; cfg_wdata = inj_word(8'h81, 1'b0, 1'b1);
    wr_valid = 1; wr_check_in = 8'h55;
    #1 chk("R8 old arm state used", wr_check_out, 8'h55);
    @(negedge clk);
    cfg_we = 0;
    #1 chk("R8 new arm next cycle", wr_check_out, 8'h55 ^ 8'h81);
    @(negedge clk);
    wr_valid = 0;
    data_write(8'h55, g); chk("R4 cleared after", g, 8'h55);
    cfg_write(INJ, inj_word(8'h0F, 1'b0, 1'b1));
    @(negedge clk);
    cfg_we = 1; cfg_addr = INJ; cfg_wdata = inj_word(8'hF0, 1'b0, 1'b1);
    wr_valid = 1; wr_check_in = 8'h00;
    #1 chk("R8 inject with old pattern", wr_check_out, 8'h0F);
    @(negedge clk);
    cfg_we = 0; wr_valid = 0;
    data_write(8'h00, g); chk("R8 rearm wins over self-clear", g, 8'hF0);
    wait_idle();
  endtask

  task automatic t_idle_hold();
    logic [7:0] g;
    cfg_write(INJ, inj_word(8'h42, 1'b1, 1'b1));
    repeat (20) @(negedge clk);
    data_write(8'h18, g); chk("R9 armed after idle", g, 8'h18 ^ 8'h42);
    wait_idle();
  endtask

  task automatic t_busy();
    logic [7:0] g;
    wait_idle();
    chk("R7 idle low", busy, 0);
    data_write(8'h01, g);
    chk("R7 high after write", busy, 1);
    @(negedge clk); @(negedge clk);
    chk("R7 high at depth", busy, 1);
    @(negedge clk);
    chk("R7 low after depth", busy, 0);
    @(negedge clk);
    wr_valid = 1;
    repeat (5) @(negedge clk);
    wr_valid = 0;
    chk("R7 high in burst", busy, 1);
    repeat (PD - 1) @(negedge clk);
    chk("R7 high before end", busy, 1);
    @(negedge clk);
    chk("R7 low after burst", busy, 0);
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_passthrough();
    t_inject(8'hF4, 1'b1, 8'h5A);
    t_inject(8'h80, 1'b1, 8'h0F);
    t_inject(8'h03, 1'b0, 8'hC3);
    t_no_arm();
    t_same_cycle();
    t_idle_hold();
    t_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule